// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an asynchronous 1M x 8 static RAM. It turns one-word host requests into RAM cycles whose strobes meet the RAM's minimum access, pulse, overlap and bus-turnaround times. Every time limit is given in nanoseconds for two speed grades. It is converted to a whole number of clock cycles by rounding up against a clock-period parameter. The host sees a valid/ready request channel with a write flag, and a one-cycle read-data strobe.

The RAM has two chip selects of opposite polarity, and the controller always moves them together. Writes are controlled by write enable, with output enable held high, so the two sides never drive the data bus at once. The controller turns on its own data driver only after the RAM's output float time has passed since output enable last rose. A sleep input parks the RAM in its deselected retention state. When sleep is released, no access starts until one full read-cycle time has passed.

The state machine has eight states. IDLE waits for work. RD_ACC holds a read and RD_END releases it. WR_SETUP presents the address and data, WR_PULSE holds write enable low, and WR_REC raises it. SLEEP is the retention state and WAKE is the recovery wait. The transitions are:
- IDLE to SLEEP when sleep is requested. Sleep has priority over a request.
- IDLE to RD_ACC or WR_SETUP when a request is accepted.
- RD_ACC to RD_END when the access count expires. RD_END always goes to IDLE.
- WR_SETUP to WR_PULSE once the float count is zero.
- WR_PULSE to WR_REC when the pulse count expires. WR_REC always goes to IDLE.
- SLEEP to WAKE when sleep is released.
- WAKE to IDLE when the recovery count expires.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released:
  - req_ready is high (with sleep_req low).
  - ram_cs_n is high and ram_cs is low.
  - ram_we_n and ram_oe_n are high.
  - dq_drive_en and rsp_valid are low.
- R2: ram_cs_n is always the inverse of ram_cs. The RAM is selected (ram_cs_n low) whenever ram_we_n or ram_oe_n is low. It is deselected in every idle, recovery, sleep and wake cycle.
- R3: A read holds ram_oe_n low and ram_we_n high for RD cycles, which is 7 at the defaults (8 ns clock, 55 ns grade), starting at the accepting edge. rsp_valid is high for exactly one cycle, the cycle after the capture edge.
- R4: rsp_rdata carries the byte last written to the address that was read. This includes the full 20-bit address and a read that directly follows a write to the same address.
- R5: A write keeps ram_oe_n high throughout and holds ram_we_n low for 6 consecutive cycles at the defaults. ram_addr does not change while ram_we_n is low, or in the cycle in which it rises.
- R6: dq_drive_en is high only while ram_oe_n is high. It goes high no earlier than 3 cycles (at least 20 ns) after ram_oe_n last rose.
- R7: dq_drive_en is high in every cycle with ram_we_n low and in the cycle in which ram_we_n rises. It is low again in the next cycle.
- R8: req_ready is high only in the idle state with sleep_req low. A request is taken on an edge where req_valid and req_ready are both high. req_ready returns in the cycle after the strobes are released: 1 cycle after the rsp_valid cycle for a read, and 1 cycle after the write-enable-rise cycle for a write.
- R9: When sleep_req is high in the idle state, it wins over req_valid. The RAM stays deselected with both strobes high, and a request held during sleep is never performed.
- R10: After sleep_req drops, req_ready rises at the 8th clock edge counted from the first edge that sees it low: one exit edge plus a 7-cycle read-cycle wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter deselected retention |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read data |
| ram_addr | output | 20 | RAM address |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_cs | output | 1 | RAM chip select, active high |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq | inout | 8 | RAM data bus |
| dq_drive_en | output | 1 | Controller is driving ram_dq |

## Verification
The properties check the cycle-level protocol on every clock:
- each strobe is asserted only while the RAM is selected;
- read and write strobes never overlap;
- the address is steady across the write pulse;
- the write pulse is long enough;
- the driver stays off through the float window and covers the whole pulse;
- the read strobe is a single pulse;
- the RAM is idle whenever ready is high.

Data correctness can only be shown by the bench scenarios:
- the byte returned for a full 20-bit address;
- write-then-read ordering;
- exact read and wake latencies;
- that a request held during sleep leaves memory unchanged.

The bench's RAM model adds the nanosecond view: pulse width, data setup, address hold at write end, and contention on the shared bus.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_END,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_REC,
        ST_SLEEP,
        ST_WAKE
    } ctrl_state_e;

    // Whole clock cycles covering a time in ns (rounded up).
    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Read strobe hold: covers both cycle time and address access.
    function automatic int rd_cycles(input int clk_ns, input bit slow);
        return imax(ns2cyc(slow ? 70 : 55, clk_ns), 1);
    endfunction

    // Write-enable low cycles. One setup cycle (address and select valid) precedes
    // the pulse and one release cycle follows it.
    function automatic int we_cycles(input int clk_ns, input bit slow);
        int pulse;
        pulse = ns2cyc(slow ? 50 : 45, clk_ns);
        pulse = imax(pulse, ns2cyc(slow ? 30 : 25, clk_ns));
        pulse = imax(pulse, ns2cyc(slow ? 60 : 50, clk_ns) - 1);
        pulse = imax(pulse, ns2cyc(slow ? 70 : 55, clk_ns) - 2);
        return imax(pulse, 1);
    endfunction

    // Cycles the RAM may keep driving after output enable rises.
    function automatic int hz_cycles(input int clk_ns, input bit slow);
        return imax(ns2cyc(slow ? 25 : 20, clk_ns), 1);
    endfunction

endpackage

// File: rtl/sram_cyc_counter.sv
module sram_cyc_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
    parameter int W = 8
) (
    inout  wire  [W-1:0] pad,
    input  logic         drive_en,
    input  logic [W-1:0] out_data,
    output logic [W-1:0] in_data
);
    assign pad     = drive_en ? out_data : {W{1'bz}};
    assign in_data = pad;
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS   = 8,
    parameter bit SPEED_70 = 1'b0,
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_cs,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    inout  wire  [DATA_W-1:0] ram_dq,
    output logic              dq_drive_en
);
    localparam int RD_CYC  = rd_cycles(CLK_NS, SPEED_70);
    localparam int WE_CYC  = we_cycles(CLK_NS, SPEED_70);
    localparam int HZ_CYC  = hz_cycles(CLK_NS, SPEED_70);
    localparam int CNT_MAX = imax(RD_CYC, WE_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int HZ_W    = $clog2(HZ_CYC + 1);

    ctrl_state_e st_q, st_d;

    logic              accept, capture;
    logic              cnt_load, cnt_zero, hz_load, hz_zero;
    logic [CNT_W-1:0]  cnt_init;
    logic              sel, drive;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, dq_in;
    logic              rsp_q;

    assign accept  = req_valid && req_ready;
    assign capture = (st_q == ST_RD_ACC) && cnt_zero;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (sleep_req)      st_d = ST_SLEEP;
                else if (req_valid) st_d = req_write ? ST_WR_SETUP : ST_RD_ACC;
            end
            ST_RD_ACC:   if (cnt_zero)   st_d = ST_RD_END;
            ST_RD_END:                   st_d = ST_IDLE;
            ST_WR_SETUP: if (hz_zero)    st_d = ST_WR_PULSE;
            ST_WR_PULSE: if (cnt_zero)   st_d = ST_WR_REC;
            ST_WR_REC:                   st_d = ST_IDLE;
            ST_SLEEP:    if (!sleep_req) st_d = ST_WAKE;
            ST_WAKE:     if (cnt_zero)   st_d = ST_IDLE;
            default:                     st_d = ST_IDLE;
        endcase
    end

    // Counter loads on state entry; the float counter loads as output enable releases
    always_comb begin
        cnt_load = (st_d != st_q);
        unique case (st_d)
            ST_RD_ACC, ST_WAKE: cnt_init = CNT_W'(RD_CYC - 1);
            ST_WR_PULSE:        cnt_init = CNT_W'(WE_CYC - 1);
            default:            cnt_init = '0;
        endcase
    end

    assign hz_load = (st_q == ST_RD_ACC) && (st_d != ST_RD_ACC);

    sram_cyc_counter #(.W(CNT_W)) u_cyc (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_init), .zero(cnt_zero)
    );

    sram_cyc_counter #(.W(HZ_W)) u_float (
        .clk(clk), .rst_n(rst_n), .load(hz_load), .load_val(HZ_W'(HZ_CYC)), .zero(hz_zero)
    );

    // Request and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= dq_in;
            rsp_q <= capture;
        end
    end

    // Moore outputs
    always_comb begin
        sel       = 1'b0;
        ram_we_n  = 1'b1;
        ram_oe_n  = 1'b1;
        drive     = 1'b0;
        req_ready = 1'b0;
        unique case (st_q)
            ST_IDLE:     req_ready = !sleep_req;
            ST_RD_ACC: begin
                sel      = 1'b1;
                ram_oe_n = 1'b0;
            end
            ST_WR_SETUP: begin
                sel   = 1'b1;
                drive = hz_zero;
            end
            ST_WR_PULSE: begin
                sel      = 1'b1;
                ram_we_n = 1'b0;
                drive    = 1'b1;
            end
            ST_WR_REC:   drive = 1'b1;
            ST_RD_END, ST_SLEEP, ST_WAKE: ;
            default: ;
        endcase
    end

    sram_dq_port #(.W(DATA_W)) u_dq (
        .pad(ram_dq), .drive_en(drive), .out_data(wdata_q), .in_data(dq_in)
    );

    assign ram_cs      = sel;
    assign ram_cs_n    = ~sel;
    assign ram_addr    = addr_q;
    assign dq_drive_en = drive;
    assign rsp_valid   = rsp_q;
    assign rsp_rdata   = rdata_q;
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS   = 8,
    parameter bit SPEED_70 = 1'b0,
    parameter int ADDR_W   = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_cs_n,
    input logic              ram_cs,
    input logic              ram_we_n,
    input logic              ram_oe_n,
    input logic              dq_drive_en
);
    localparam int WE_CYC = we_cycles(CLK_NS, SPEED_70);
    localparam int HZ_CYC = hz_cycles(CLK_NS, SPEED_70);

    int we_lo_cnt;
    int oe_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= 0;
            oe_hi_cnt <= HZ_CYC;
        end else begin
            we_lo_cnt <= ram_we_n ? 0 : ((we_lo_cnt < WE_CYC) ? we_lo_cnt + 1 : we_lo_cnt);
            oe_hi_cnt <= !ram_oe_n ? 0 : ((oe_hi_cnt < HZ_CYC) ? oe_hi_cnt + 1 : oe_hi_cnt);
        end
    end

    // R2
    strobe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_we_n || !ram_oe_n) |-> (!ram_cs_n && ram_cs));

    // R2
    sel_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs_n != ram_cs);

    // R3
    no_oe_we_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> ram_we_n);

    // R3
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5
    addr_steady_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_we_n && $past(!ram_we_n)) |-> $stable(ram_addr));

    // R5
    we_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (we_lo_cnt >= WE_CYC));

    // R5
    addr_held_at_we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> $stable(ram_addr));

    // R6
    drive_after_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive_en |-> (ram_oe_n && oe_hi_cnt >= HZ_CYC));

    // R7
    drive_covers_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_we_n || $rose(ram_we_n)) |-> dq_drive_en);

    // R8
    idle_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_cs_n && ram_we_n && ram_oe_n && !dq_drive_en));
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
    .CLK_NS(CLK_NS), .SPEED_70(SPEED_70), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_cs(ram_cs),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .dq_drive_en(dq_drive_en)
);

// File: tb/sim_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_sram_cycle_ctrl;
    // Expected figures at the defaults (8 ns clock, 55 ns grade), from the requirements
    localparam int RD_EXP   = 7;   // R3
    localparam int WE_EXP   = 6;   // R5
    localparam int WAKE_EXP = 8;   // R10
    localparam int T_CLK    = 8;
    localparam int T_WP     = 45;
    localparam int T_DW     = 25;
    localparam int T_OHZ    = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_req = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, ram_cs_n, ram_cs, ram_we_n, ram_oe_n, dq_drive_en;
    logic [7:0]  rsp_rdata;
    logic [19:0] ram_addr;
    wire  [7:0]  dq;

    always #4 clk = ~clk;

    sram_cycle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_cs(ram_cs),
        .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_dq(dq),
        .dq_drive_en(dq_drive_en)
    );

    // ---------------- behavioural RAM with timing monitor ----------------
    logic [7:0]  m_dat [64];
    logic [19:0] m_tag [64];
    logic        m_vld [64];
    logic [7:0]  m_q;
    wire         m_sel   = !ram_cs_n && ram_cs;
    wire         m_drive = m_sel && !ram_oe_n && ram_we_n;

    always_comb begin
        if (m_vld[ram_addr[5:0]] && m_tag[ram_addr[5:0]] == ram_addr) m_q = m_dat[ram_addr[5:0]];
        else m_q = 8'hEE;
    end
    assign dq = m_drive ? m_q : 8'hzz;

    int          viol = 0;
    int          oe_hi_n = 99, we_lo_n = 0, dstab_n = 0;
    logic        prev_we_n = 1'b1, prev_drv = 1'b0;
    logic [7:0]  prev_dq = '0;
    logic [19:0] wr_addr = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
            oe_hi_n = 99;
            prev_we_n = 1'b1;
            prev_drv = 1'b0;
        end else begin
            if (dq_drive_en && m_drive) begin viol++; $display("model: bus contention at %0t", $time); end
            if (!ram_oe_n) oe_hi_n = -1;
            else if (oe_hi_n < 99) oe_hi_n++;
            if (dq_drive_en && oe_hi_n * T_CLK < T_OHZ) begin viol++; $display("model: drive inside float window at %0t", $time); end
            if (dq_drive_en) begin
                if (prev_drv && dq === prev_dq) dstab_n++;
                else dstab_n = 1;
            end else dstab_n = 0;
            if (!ram_we_n) begin
                if (!m_sel)       begin viol++; $display("model: write enable without select at %0t", $time); end
                if (!dq_drive_en) begin viol++; $display("model: write data not driven at %0t", $time); end
                if (prev_we_n) begin
                    we_lo_n = 1;
                    wr_addr = ram_addr;
                end else begin
                    we_lo_n++;
                    if (ram_addr != wr_addr) begin viol++; $display("model: address moved in pulse at %0t", $time); end
                end
            end else if (!prev_we_n) begin
                if (we_lo_n * T_CLK < T_WP)        begin viol++; $display("model: short write pulse at %0t", $time); end
                if ((dstab_n - 1) * T_CLK < T_DW)  begin viol++; $display("model: short data setup at %0t", $time); end
                if (ram_addr != wr_addr)           begin viol++; $display("model: address hold at write end at %0t", $time); end
                if (!dq_drive_en)                  begin viol++; $display("model: data hold at write end at %0t", $time); end
                m_dat[wr_addr[5:0]] = dq;
                m_tag[wr_addr[5:0]] = wr_addr;
                m_vld[wr_addr[5:0]] = 1'b1;
            end
            prev_we_n = ram_we_n;
            prev_dq   = dq;
            prev_drv  = dq_drive_en;
        end
    end

    // ---------------- checking ----------------
    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] shadow [logic [19:0]];

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic issue(input bit wr, input logic [19:0] a, input logic [7:0] d);
        int lo = 0, since = 0, oe_bad = 0, drv_bad = 0;
        int olo = 0, lat = -1, pulses = 0, k;
        logic [7:0] got = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        while (k < 40 && !req_ready) begin
            if (wr) begin
                if (!ram_we_n) begin
                    lo++; since = 0;
                    if (!dq_drive_en) drv_bad++;
                end else if (lo > 0) since++;
                if (!ram_oe_n) oe_bad++;
            end else begin
                if (!ram_oe_n) olo++;
                if (rsp_valid) begin
                    pulses++;
                    if (lat < 0) begin lat = k; got = rsp_rdata; end
                end
            end
            @(negedge clk);
            k++;
        end
        if (wr) begin
            shadow[a] = d;
            check(lo == WE_EXP, "R5", "write enable low cycles", lo, WE_EXP);
            check(oe_bad == 0, "R5", "output enable low during write", oe_bad, 0);
            check(drv_bad == 0, "R7", "pulse cycles without driver", drv_bad, 0);
            check(since == 1, "R8", "cycles from release to ready (write)", since, 1);
        end else begin
            check(lat == RD_EXP, "R3", "read capture latency", lat, RD_EXP);
            check(olo == RD_EXP, "R3", "output enable low cycles", olo, RD_EXP);
            check(pulses == 1, "R3", "rsp_valid pulse count", pulses, 1);
            check(k == RD_EXP + 1, "R8", "cycles to ready (read)", k, RD_EXP + 1);
            check(shadow.exists(a) && got == shadow[a], "R4", "read data", got, shadow.exists(a) ? shadow[a] : 0);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [19:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam vec_t VECS [0:9] = '{
        '{1'b1, 20'h00000, 8'hA5},
        '{1'b1, 20'hFFFFF, 8'h3C},
        '{1'b1, 20'h12345, 8'h81},
        '{1'b0, 20'h00000, 8'h00},
        '{1'b0, 20'hFFFFF, 8'h00},
        '{1'b0, 20'h12345, 8'h00},
        '{1'b1, 20'h12345, 8'h7E},
        '{1'b0, 20'h12345, 8'h00},
        '{1'b1, 20'h80041, 8'h11},
        '{1'b0, 20'h80041, 8'h00}
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int lat;
        bit bad;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(ram_cs_n == 1'b1 && ram_cs == 1'b0, "R1", "selects in reset", {ram_cs_n, ram_cs}, 2);
        check(ram_we_n && ram_oe_n, "R1", "strobes in reset", {ram_we_n, ram_oe_n}, 3);
        check(!dq_drive_en && !rsp_valid, "R1", "driver/rsp in reset", {dq_drive_en, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(ram_cs_n == 1'b1 && ram_cs == 1'b0, "R2", "idle deselected", {ram_cs_n, ram_cs}, 2);

        // Table walk: back-to-back writes, back-to-back reads, write-then-read
        foreach (VECS[i]) issue(VECS[i].wr, VECS[i].addr, VECS[i].data);
        check(viol == 0, "R6", "model timing/contention violations", viol, 0);

        // R9: sleep wins over a simultaneous request; held request is ignored
        @(negedge clk);
        sleep_req = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00000; req_wdata = 8'hFF;
        bad = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (req_ready || !ram_we_n || !ram_oe_n || !ram_cs_n || ram_cs || dq_drive_en) bad = 1'b1;
        end
        check(!bad, "R9", "activity while sleeping", bad, 0);
        check(ram_cs_n == 1'b1 && ram_cs == 1'b0, "R2", "sleep deselected", {ram_cs_n, ram_cs}, 2);

        // R10: wake wait
        sleep_req = 1'b0;
        req_valid = 1'b0;
        lat = 0;
        while (!req_ready && lat < 40) begin
            @(negedge clk);
            lat++;
            if (!req_ready && (!ram_cs_n || !ram_we_n || !ram_oe_n)) bad = 1'b1;
        end
        check(lat == WAKE_EXP, "R10", "cycles from sleep release to ready", lat, WAKE_EXP);
        check(!bad, "R10", "strobes during wake", bad, 0);

        // R9: memory unchanged by the request held during sleep
        issue(1'b0, 20'h00000, 8'h00);

        // Read right after sleep exit then write right after a read (turnaround)
        issue(1'b1, 20'h00000, 8'h5A);
        issue(1'b0, 20'h00000, 8'h00);
        check(viol == 0, "R5", "model violations after turnaround", viol, 0);
        @(negedge clk);
        check(!dq_drive_en && req_ready, "R7", "driver off when idle", {dq_drive_en, req_ready}, 1);
        finish_up();
    end
endmodule